// File: doc/BRIEF.md
# Ping-pong DMA channel register block

This block is a single peripheral DMA channel with two buffer slots, A and B. Software reaches it through a 32-bit register window that is 0x20 bytes long. For each slot, software writes a start address and a byte count, then sets the slot's start bit. While the run bit is set, the channel serves the slot that the buffer-in-use flag selects. Each device request strobe moves one beat. The beat goes out on a valid/ready interface that carries the address, the direction and the beat width.

When the active slot's count reaches zero, the channel does three things:
- it retires the slot;
- it flags the slot done;
- it flips buffer-in-use.

Software can therefore refill one slot while the other one drains, and the channel moves between them without waiting for software. The control word has separate aliases for write-one-to-set, write-one-to-clear and read. Error and done status raise one interrupt line, gated by an enable bit. A misaligned start or a count that does not fit the beat width is rejected when the slot begins.

Top module: `pingpong_dma_chan`

## Requirements
- R1: After reset the control word reads 0, buffer-in-use selects slot A, both slots' address and count registers read 0, irq is low and beat_valid is low.
- R2: Register word index reg_addr[4:2] selects the register: 0 config, 1 set alias, 2 clear alias, 3 control read, 4 slot A address, 5 slot A count, 6 slot B address, 7 slot B count. Indices 1 and 2 read as 0. The control word bits are:

  | Bit | Meaning |
  |-----|---------|
  | 0 | run |
  | 1 | interrupt enable |
  | 2 | error |
  | 3 | done A |
  | 4 | start A |
  | 5 | done B |
  | 6 | start B |
  | 7 | buffer-in-use (0 = A, 1 = B) |

  A write to the set alias ORs wdata[6:0] into bits 6:0. A write to the clear alias clears the bits of 6:0 written as one. Software cannot write bit 7.
- R3: While run is 1, the slot selected by buffer-in-use has its start bit set, and its count is non-zero, a high dev_req raises beat_valid with beat_addr equal to that slot's current address. Each accepted beat (beat_valid and beat_ready) adds the beat size to the address and subtracts it from the count.
- R4: Config bit 3 selects the beat size: 0 gives 1 byte, 1 gives 2 bytes. beat_wide mirrors this bit.
- R5: When the active slot is started and running with a count of 0, the next clock clears its start bit, sets its done bit and toggles buffer-in-use.
- R6: With both slots started, slot B is served after slot A completes, with no software action.
- R7: Clearing run stops all beats and keeps the addresses, counts and start bits. Setting run again resumes from the same point.
- R8: When a slot begins, the start address is checked. If the address is not 4-byte aligned, or the beat is 2 bytes wide and the count is odd, the error bit is set, the slot's start bit is cleared, no beat is issued and buffer-in-use is unchanged. Addresses that advance during a transfer are not checked again.
- R9: irq equals interrupt enable AND (error OR done A OR done B). Clearing those bits through the clear alias drops it.
- R10: Count registers are 13 bits wide. A written value is truncated to wdata[12:0] and reads back zero-extended.
- R11: While beat_valid is high and beat_ready is low, the address and count do not change.
- R12: The config register keeps wdata[7:0] and reads back zero-extended. beat_to_mem mirrors config bit 0 (1 = device to memory).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte offset within the window; bits 4:2 select the word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| dev_req | input | 1 | Device request strobe |
| beat_valid | output | 1 | A beat is offered |
| beat_ready | input | 1 | The beat is accepted this cycle |
| beat_addr | output | 32 | Memory address of the offered beat |
| beat_wide | output | 1 | Beat is 2 bytes (otherwise 1 byte) |
| beat_to_mem | output | 1 | Direction: 1 means device to memory |
| irq | output | 1 | Interrupt request |

## Verification
The bench drains slot A and then slot B in byte mode from a single set-alias write. If the hand-off were wrong, the channel would stall after slot A or serve A again. Byte-mode addresses become unaligned as the transfer advances, so a design that rechecked alignment on every beat would raise a false error in the middle of the transfer. Stalls on beat_ready and pauses on run are checked against counts that must not move. Faults from a misaligned start and from an odd count in 2-byte mode must set error and leave buffer-in-use and the address untouched. Writes of bit 7 through the set alias, and writes of counts wider than 13 bits, must have no visible effect beyond the documented ones.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;
  localparam int CTRL_W = 8;
  localparam int B_RUN  = 0;
  localparam int B_IE   = 1;
  localparam int B_ERR  = 2;
  localparam int B_DNA  = 3;
  localparam int B_STA  = 4;
  localparam int B_DNB  = 5;
  localparam int B_STB  = 6;
  localparam int B_BIU  = 7;

  localparam logic [2:0] W_CFG  = 3'd0;
  localparam logic [2:0] W_SET  = 3'd1;
  localparam logic [2:0] W_CLR  = 3'd2;
  localparam logic [2:0] W_STAT = 3'd3;
  localparam logic [2:0] W_AADR = 3'd4;
  localparam logic [2:0] W_ACNT = 3'd5;
  localparam logic [2:0] W_BADR = 3'd6;
  localparam logic [2:0] W_BCNT = 3'd7;

  function automatic logic [1:0] beat_bytes(input logic wide);
    return wide ? 2'd2 : 2'd1;
  endfunction

  function automatic logic start_bad(input logic [1:0] addr_lo, input logic cnt_lsb,
                                     input logic wide);
    return (addr_lo != 2'b00) || (wide && cnt_lsb);
  endfunction

  function automatic int strt_pos(input logic slot);
    return slot ? B_STB : B_STA;
  endfunction

  function automatic int done_pos(input logic slot);
    return slot ? B_DNB : B_DNA;
  endfunction
endpackage

// File: rtl/pp_dma_slot.sv
module pp_dma_slot #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_addr,
  input  logic              ld_cnt,
  input  logic [DATA_W-1:0] wdata,
  input  logic              step,
  input  logic [1:0]        step_bytes,
  output logic [DATA_W-1:0] addr_q,
  output logic [CNT_W-1:0]  cnt_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (ld_addr)   addr_q <= wdata;
      else if (step) addr_q <= addr_q + DATA_W'(step_bytes);
      if (ld_cnt)    cnt_q  <= wdata[CNT_W-1:0];
      else if (step) cnt_q  <= cnt_q - CNT_W'(step_bytes);
    end
  end
endmodule

// File: rtl/pp_dma_ctrl.sv
module pp_dma_ctrl
  import pp_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [6:0]        wmask,
  input  logic [1:0]        slot_bad,
  input  logic [1:0]        slot_zero,
  input  logic              dev_req,
  input  logic              beat_ready,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              sel,
  output logic              beat_go,
  output logic              ev_fault,
  output logic              ev_finish,
  output logic              ev_fire
);
  logic [CTRL_W-1:0] ctrl_n;
  logic [1:0]        chk_q, chk_n;
  logic              act;

  assign sel = ctrl_q[B_BIU];
  assign act = ctrl_q[B_RUN] && ctrl_q[strt_pos(sel)];
  assign ev_fault  = act && !chk_q[sel] && slot_bad[sel];
  assign ev_finish = act && !ev_fault && slot_zero[sel];
  assign beat_go   = act && !ev_fault && !slot_zero[sel] && dev_req;
  assign ev_fire   = beat_go && beat_ready;

  always_comb begin
    ctrl_n = ctrl_q;
    if (ev_fault) begin
      ctrl_n[B_ERR] = 1'b1;
      ctrl_n[strt_pos(sel)] = 1'b0;
    end
    if (ev_finish) begin
      ctrl_n[strt_pos(sel)] = 1'b0;
      ctrl_n[done_pos(sel)] = 1'b1;
      ctrl_n[B_BIU] = ~sel;
    end
    if (set_we) ctrl_n[6:0] = ctrl_n[6:0] | wmask;
    if (clr_we) ctrl_n[6:0] = ctrl_n[6:0] & ~wmask;
  end

  for (genvar s = 0; s < 2; s++) begin : g_chk
    assign chk_n[s] = ctrl_n[strt_pos(1'(s))] &&
                      (chk_q[s] || (act && !ev_fault && (sel == 1'(s))));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      chk_q  <= '0;
    end else begin
      ctrl_q <= ctrl_n;
      chk_q  <= chk_n;
    end
  end
endmodule

// File: rtl/pingpong_dma_chan.sv
module pingpong_dma_chan
  import pp_dma_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 13,
  parameter int CFG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [4:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              dev_req,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [DATA_W-1:0] beat_addr,
  output logic              beat_wide,
  output logic              beat_to_mem,
  output logic              irq
);
  localparam int NSLOT = 2;

  logic [2:0]        widx;
  logic [CFG_W-1:0]  cfg_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              sel, ev_fault, ev_finish, ev_fire;
  logic [1:0]        step_bytes;
  logic [DATA_W-1:0] saddr [NSLOT];
  logic [CNT_W-1:0]  scnt  [NSLOT];
  logic [1:0]        slot_bad, slot_zero;

  assign widx        = reg_addr[4:2];
  assign beat_wide   = cfg_q[3];
  assign beat_to_mem = cfg_q[0];
  assign step_bytes  = beat_bytes(beat_wide);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (reg_wr && widx == W_CFG) cfg_q <= reg_wdata[CFG_W-1:0];
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam logic [2:0] AIDX = (s == 0) ? W_AADR : W_BADR;
    localparam logic [2:0] CIDX = (s == 0) ? W_ACNT : W_BCNT;
    pp_dma_slot #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .ld_addr    (reg_wr && widx == AIDX),
      .ld_cnt     (reg_wr && widx == CIDX),
      .wdata      (reg_wdata),
      .step       (ev_fire && sel == 1'(s)),
      .step_bytes (step_bytes),
      .addr_q     (saddr[s]),
      .cnt_q      (scnt[s])
    );
    assign slot_bad[s]  = start_bad(saddr[s][1:0], scnt[s][0], beat_wide);
    assign slot_zero[s] = (scnt[s] == '0);
  end

  pp_dma_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_we     (reg_wr && widx == W_SET),
    .clr_we     (reg_wr && widx == W_CLR),
    .wmask      (reg_wdata[6:0]),
    .slot_bad   (slot_bad),
    .slot_zero  (slot_zero),
    .dev_req    (dev_req),
    .beat_ready (beat_ready),
    .ctrl_q     (ctrl_q),
    .sel        (sel),
    .beat_go    (beat_valid),
    .ev_fault   (ev_fault),
    .ev_finish  (ev_finish),
    .ev_fire    (ev_fire)
  );

  assign beat_addr = saddr[sel];
  assign irq = ctrl_q[B_IE] && (ctrl_q[B_ERR] || ctrl_q[B_DNA] || ctrl_q[B_DNB]);

  always_comb begin
    reg_rdata = '0;
    case (widx)
      W_CFG:  reg_rdata = DATA_W'(cfg_q);
      W_STAT: reg_rdata = DATA_W'(ctrl_q);
      W_AADR: reg_rdata = saddr[0];
      W_ACNT: reg_rdata = DATA_W'(scnt[0]);
      W_BADR: reg_rdata = saddr[1];
      W_BCNT: reg_rdata = DATA_W'(scnt[1]);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pingpong_dma_chan_checker.sv
module pingpong_dma_chan_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [7:0]  ctrl_q,
  input logic        ev_fault,
  input logic        ev_finish,
  input logic        ev_fire,
  input logic        beat_valid,
  input logic        beat_ready,
  input logic [31:0] beat_addr,
  input logic [1:0]  step_bytes,
  input logic        irq
);
  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[1] |-> !irq);
  assert_irq_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[1] && ctrl_q[2]) |-> irq);
  assert_events_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_fault, ev_finish, ev_fire}));
  assert_handoff_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_finish |=> ctrl_q[7] != $past(ctrl_q[7]));
  assert_fault_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fault && !reg_wr) |=> ctrl_q[2]);
  assert_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready && !reg_wr) |=> $stable(beat_addr));
  assert_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fire && !reg_wr) |=> beat_addr == $past(beat_addr) + 32'($past(step_bytes)));
  assert_run_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> ctrl_q[0]);
endmodule

bind pingpong_dma_chan pingpong_dma_chan_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .ctrl_q     (ctrl_q),
  .ev_fault   (ev_fault),
  .ev_finish  (ev_finish),
  .ev_fire    (ev_fire),
  .beat_valid (beat_valid),
  .beat_ready (beat_ready),
  .beat_addr  (beat_addr),
  .step_bytes (step_bytes),
  .irq        (irq)
);

// File: tb/pingpong_dma_chan_test.sv
`timescale 1ns/1ps
module pingpong_dma_chan_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dev_req = 1'b0;
  logic        beat_valid;
  logic        beat_ready = 1'b0;
  logic [31:0] beat_addr;
  logic        beat_wide, beat_to_mem, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 1'b0;

  always #2.5 clk = ~clk;

  pingpong_dma_chan uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_req(dev_req),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_addr(beat_addr),
    .beat_wide(beat_wide), .beat_to_mem(beat_to_mem), .irq(irq)
  );

  // Behavioural reference model
  bit          m_run, m_ie, m_err, m_biu;
  bit          m_done [2];
  bit          m_go   [2];
  bit          m_seen [2];
  logic [31:0] m_adr  [2];
  int          m_cnt  [2];
  logic [7:0]  m_cfg;

  function automatic logic [7:0] m_word();
    return {m_biu, m_go[1], m_done[1], m_go[0], m_done[0], m_err, m_ie, m_run};
  endfunction

  function automatic bit m_active();
    return m_run && m_go[m_biu];
  endfunction

  function automatic bit m_broken(int s);
    return (m_adr[s] % 4 != 0) || (m_cfg[3] && (m_cnt[s] % 2 == 1));
  endfunction

  function automatic bit m_faulting();
    return m_active() && !m_seen[m_biu] && m_broken(int'(m_biu));
  endfunction

  function automatic bit m_offer();
    return m_active() && !m_faulting() && m_cnt[m_biu] != 0 && dev_req;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_ie = 0; m_err = 0; m_biu = 0; m_cfg = '0;
      for (int s = 0; s < 2; s++) begin
        m_done[s] = 0; m_go[s] = 0; m_seen[s] = 0; m_adr[s] = '0; m_cnt[s] = 0;
      end
    end else begin
      int  s;
      int  step;
      bit  act, flt, fin, fire;
      logic [7:0] w;
      s    = int'(m_biu);
      step = m_cfg[3] ? 2 : 1;
      act  = m_active();
      flt  = m_faulting();
      fin  = act && !flt && m_cnt[s] == 0;
      fire = m_offer() && beat_ready;
      if (flt) begin m_err = 1; m_go[s] = 0; end
      if (fin) begin m_go[s] = 0; m_done[s] = 1; m_biu = !m_biu; end
      if (fire) begin m_adr[s] = m_adr[s] + step; m_cnt[s] = m_cnt[s] - step; end
      if (reg_wr) begin
        case (reg_addr >> 2)
          0: m_cfg = reg_wdata[7:0];
          1, 2: begin
            w = m_word();
            if ((reg_addr >> 2) == 1) w[6:0] = w[6:0] | reg_wdata[6:0];
            else w[6:0] = w[6:0] & ~reg_wdata[6:0];
            {m_go[1], m_done[1], m_go[0], m_done[0], m_err, m_ie, m_run} = w[6:0];
          end
          4: m_adr[0] = reg_wdata;
          5: m_cnt[0] = reg_wdata % 8192;
          6: m_adr[1] = reg_wdata;
          7: m_cnt[1] = reg_wdata % 8192;
          default: ;
        endcase
      end
      for (int k = 0; k < 2; k++)
        m_seen[k] = m_go[k] && (m_seen[k] || (act && !flt && s == k));
    end
  end

  function automatic logic [31:0] m_read(logic [4:0] a);
    case (a >> 2)
      0: return {24'd0, m_cfg};
      3: return {24'd0, m_word()};
      4: return m_adr[0];
      5: return 32'(m_cnt[0]);
      6: return m_adr[1];
      7: return 32'(m_cnt[1]);
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison with the model
  always @(negedge clk) begin
    #2;
    if (rst_n && !done_flag) begin
      logic exp_irq;
      exp_irq = m_ie && (m_err || m_done[0] || m_done[1]);
      check(irq == exp_irq, "R9 irq", 32'(irq), 32'(exp_irq));
      check(beat_valid == m_offer(), "R3 beat_valid", 32'(beat_valid), 32'(m_offer()));
      if (beat_valid)
        check(beat_addr == m_adr[m_biu], "R3 beat_addr", beat_addr, m_adr[m_biu]);
      check(reg_rdata == m_read(reg_addr), "R2 read data", reg_rdata, m_read(reg_addr));
      check(beat_wide == m_cfg[3], "R4 beat_wide", 32'(beat_wide), 32'(m_cfg[3]));
      check(beat_to_mem == m_cfg[0], "R12 direction", 32'(beat_to_mem), 32'(m_cfg[0]));
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, logic [31:0] exp, string tag);
    reg_addr = a;
    #1;
    check(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    idle(1);
    // R1: reset state
    rd(5'h0C, 32'h0, "R1 control after reset");
    rd(5'h14, 32'h0, "R1 slot A count after reset");
    rd(5'h1C, 32'h0, "R1 slot B count after reset");
    check(irq == 1'b0 && beat_valid == 1'b0, "R1 outputs idle", {irq, beat_valid}, 0);

    // R2: set/clear aliases, bit 7 not writable, alias reads
    wr(5'h04, 32'h0000_0082);
    rd(5'h0C, 32'h02, "R2 set ORs bits, bit7 ignored");
    rd(5'h04, 32'h0, "R2 set alias reads zero");
    wr(5'h08, 32'h0000_00FF);
    rd(5'h0C, 32'h00, "R2 clear alias");

    // R10: count truncation
    wr(5'h14, 32'hFFFF_FFFF);
    rd(5'h14, 32'h1FFF, "R10 count truncated to 13 bits");

    // R5/R6: byte mode ping-pong, unaligned mid-transfer addresses
    wr(5'h00, 32'h0);
    wr(5'h10, 32'h100); wr(5'h14, 32'd3);
    wr(5'h18, 32'h200); wr(5'h1C, 32'd2);
    dev_req = 1'b1; beat_ready = 1'b1;
    wr(5'h04, 32'h53);
    check(beat_valid && beat_addr == 32'h100, "R3 first beat", beat_addr, 32'h100);
    idle(12);
    rd(5'h0C, 32'h2B, "R6 both slots done, buffer back to A");
    rd(5'h10, 32'h103, "R3 slot A address advanced");
    rd(5'h18, 32'h202, "R6 slot B served");
    check(irq == 1'b1, "R9 irq on done", 32'(irq), 1);
    wr(5'h08, 32'h2C);
    check(irq == 1'b0, "R9 irq cleared", 32'(irq), 0);

    // R4/R12/R11/R7: half-word mode, stall, pause/resume
    dev_req = 1'b0;
    wr(5'h00, 32'h09);
    rd(5'h00, 32'h09, "R12 config readback");
    check(beat_wide && beat_to_mem, "R4 wide beat flags", {beat_wide, beat_to_mem}, 3);
    wr(5'h10, 32'h300); wr(5'h14, 32'd4);
    beat_ready = 1'b0; dev_req = 1'b1;
    wr(5'h04, 32'h10);
    idle(3);
    check(beat_valid && beat_addr == 32'h300, "R11 stalled beat held", beat_addr, 32'h300);
    rd(5'h14, 32'd4, "R11 count held during stall");
    beat_ready = 1'b1;
    @(negedge clk);
    rd(5'h10, 32'h302, "R4 two-byte step");
    dev_req = 1'b0;
    wr(5'h08, 32'h01);
    dev_req = 1'b1;
    idle(3);
    check(beat_valid == 1'b0, "R7 paused no beat", 32'(beat_valid), 0);
    rd(5'h14, 32'd2, "R7 count kept while paused");
    rd(5'h0C, 32'h12, "R7 start kept while paused");
    wr(5'h04, 32'h01);
    idle(5);
    rd(5'h14, 32'd0, "R7 resumed and drained");
    rd(5'h0C, 32'h8B, "R5 done A, buffer moved to B");

    // R8: faults (buffer now at B)
    wr(5'h08, 32'h09);
    wr(5'h18, 32'h402); wr(5'h1C, 32'd4);
    wr(5'h04, 32'h41);
    idle(3);
    rd(5'h0C, 32'h87, "R8 misaligned start faults");
    rd(5'h18, 32'h402, "R8 no beat on fault");
    check(irq == 1'b1, "R8 fault raises irq", 32'(irq), 1);
    wr(5'h08, 32'h04);
    wr(5'h18, 32'h500); wr(5'h1C, 32'd3);
    wr(5'h04, 32'h40);
    idle(3);
    rd(5'h0C, 32'h87, "R8 odd count in wide mode faults");
    rd(5'h1C, 32'd3, "R8 count untouched on fault");

    dev_req = 1'b0; beat_ready = 1'b0;
    idle(2);
    finish_run();
  end
endmodule